// File: doc/BRIEF.md
# Status Register Masked Write Unit

This block owns a processor's 32-bit current status register and its 32-bit saved copy. It applies the update caused by a move-to-status instruction. The instruction supplies a data word, a four-bit lane-select field, a qualifier saying whether execution-state bits may change, a configuration bit that makes fast interrupts non-maskable, and a choice of target register. Both registers change on the rising clock edge of a cycle in which the write strobe is high.

For the saved register, each select bit opens a fixed group of bits. For the current register, which bits a select bit opens depends on four things:

- the privilege level, taken from the current mode field,
- the state qualifier,
- whether the written mode value is a legal encoding,
- the non-maskable fast-interrupt rule.

An attempt to write an illegal mode encoding is dropped and flagged on `mode_err`, and the remaining selected bits are still written. Exception entry and return are handled elsewhere.

Top module: `psr_write_unit`

## Requirements
- R1: Synchronous reset, active high, loads both registers with 0x000000D3 and clears `mode_err`. This value is supervisor mode 10011 with bits 7 and 6 set.
- R2: A register changes only on a clock edge with `wr_en` high. Its new value is (old AND NOT mask) OR (data AND mask).
- R3: For the current register, select bit 3 opens bits 31:24 when `state_qual` is 1, and only bits 31:27 when it is 0.
- R4: Select bit 2 opens bits 19:16 of whichever register is targeted. Bits 23:20 are never written.
- R5: For the current register, select bit 1 opens a range of bits. The top of the range is bit 15 when `state_qual` is 1 and bit 9 otherwise. The bottom of the range is bit 8 when privileged and bit 9 in user mode.
- R6: For the current register, select bit 0 opens bits 7:6 only when privileged.
- R7: Mode bits 4:0 of the current register are written only by select bit 0, only when privileged, and only when the data's mode field is legal. The legal modes are 10000, 10001, 10010, 10011, 10110, 10111, 11011 and 11111.
- R8: A privileged write to the current register with select bit 0 and an illegal mode raises `mode_err` for exactly the cycle after the write edge. The other selected bits are still updated.
- R9: For the current register, select bit 0 with `state_qual` high opens bit 5, at any privilege level.
- R10: When `nmfi_cfg` is 1 and bit 6 of the current register is 0 before the write, bit 6 of the result is 0 after a write to the current register.
- R11: For the saved register, select bits 3, 1 and 0 open bits 31:24, 15:8 and 7:0 in full. These groups do not depend on privilege, qualifier or mode legality, and a saved write never sets `mode_err`.
- R12: The core is privileged when the current register's mode field, sampled before the write, is not 10000. A write to one register leaves the other unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| sel_saved | input | 1 | 1 targets the saved register, 0 the current register |
| lane_sel | input | 4 | Lane-select field of the instruction |
| state_qual | input | 1 | Allows execution-state bits to be written |
| nmfi_cfg | input | 1 | Non-maskable fast-interrupt configuration |
| wr_data | input | 32 | Value to merge |
| cur_psr | output | 32 | Current status register |
| saved_psr | output | 32 | Saved status register |
| mode_err | output | 1 | Pulse reporting a rejected mode write |

## Verification
Two behaviours can land on the same edge.

The first is rejecting an illegal mode while other lanes are written. A single write with all four select bits set carries mode 00000. The bench then checks that the flag is raised, that the mode field is unchanged, and that the flag, interrupt and upper bits still take their new values.

The second is the non-maskable fast-interrupt clamp acting on a write that itself sets bit 6. The bench first clears bit 6 and then writes a value with bit 6 set. Bit 6 must read 0 while bit 7 and the mode bits take the written value.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int PSR_W    = 32;
  localparam int LANES    = 4;
  localparam int MODE_W   = 5;
  localparam int FIQ_BIT  = 6;
  localparam int EXEC_BIT = 5;
  localparam logic [MODE_W-1:0] MODE_USER = 5'b10000;
  localparam logic [MODE_W-1:0] MODE_SUPV = 5'b10011;
  localparam logic [PSR_W-1:0]  PSR_RESET =
    {{(PSR_W-8){1'b0}}, 3'b110, MODE_SUPV};

  function automatic logic [PSR_W-1:0] span(input int hi, input int lo);
    logic [PSR_W-1:0] m;
    for (int i = 0; i < PSR_W; i++) m[i] = (i >= lo) && (i <= hi);
    return m;
  endfunction
endpackage

// File: rtl/psr_mode_check.sv
module psr_mode_check
  import psr_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  output logic              legal
);
  always_comb begin
    unique case (mode)
      5'b10000, 5'b10001, 5'b10010, 5'b10011,
      5'b10110, 5'b10111, 5'b11011, 5'b11111: legal = 1'b1;
      default:                                legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/psr_lane_mask.sv
module psr_lane_mask
  import psr_pkg::*;
#(
  parameter bit IS_SAVED = 1'b0
) (
  input  logic [LANES-1:0] lanes,
  input  logic             qual,
  input  logic             priv,
  input  logic             mode_ok,
  output logic [PSR_W-1:0] mask
);
  generate
    if (IS_SAVED) begin : g_saved
      logic [LANES-1:0][PSR_W-1:0] part;
      for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int LO = 8 * i;
        localparam int HI = (i == 2) ? 19 : 8 * i + 7;
        assign part[i] = lanes[i] ? span(HI, LO) : '0;
      end
      assign mask = part[0] | part[1] | part[2] | part[3];
    end else begin : g_current
      logic [PSR_W-1:0] m3, m2, m1, m0;
      always_comb begin
        m3 = lanes[3] ? span(31, qual ? 24 : 27) : '0;
        m2 = lanes[2] ? span(19, 16) : '0;
        m1 = lanes[1] ? span(qual ? 15 : 9, priv ? 8 : 9) : '0;
        m0 = '0;
        if (lanes[0]) begin
          if (priv) begin
            m0[7:6] = 2'b11;
            if (mode_ok) m0[MODE_W-1:0] = '1;
          end
          if (qual) m0[EXEC_BIT] = 1'b1;
        end
      end
      assign mask = m3 | m2 | m1 | m0;
    end
  endgenerate

  // R4: bits 23:20 are never opened
  always_comb a_r4_gap_closed: assert (mask[23:20] == 4'b0);
  // R5: user mode never opens bit 8 of the current register
  always_comb a_r5_user_bit8: assert (IS_SAVED || priv || !mask[8]);
  // R3: without qualifier, bits 26:24 of the current register stay closed
  always_comb a_r3_low_top: assert (IS_SAVED || qual || mask[26:24] == 3'b0);
endmodule

// File: rtl/psr_write_unit.sv
module psr_write_unit
  import psr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             sel_saved,
  input  logic [3:0]       lane_sel,
  input  logic             state_qual,
  input  logic             nmfi_cfg,
  input  logic [31:0]      wr_data,
  output logic [31:0]      cur_psr,
  output logic [31:0]      saved_psr,
  output logic             mode_err
);
  logic [PSR_W-1:0] cur_q, sav_q;
  logic             err_q;
  logic             priv, data_mode_ok, held_mode_ok, bad_try;
  logic [PSR_W-1:0] cur_mask, sav_mask, cur_next, sav_next;

  assign priv = (cur_q[MODE_W-1:0] != MODE_USER);

  psr_mode_check u_data_mode (.mode(wr_data[MODE_W-1:0]), .legal(data_mode_ok));
  psr_mode_check u_held_mode (.mode(cur_q[MODE_W-1:0]),   .legal(held_mode_ok));

  psr_lane_mask #(.IS_SAVED(1'b0)) u_cur_mask (
    .lanes(lane_sel), .qual(state_qual), .priv(priv),
    .mode_ok(data_mode_ok), .mask(cur_mask));

  psr_lane_mask #(.IS_SAVED(1'b1)) u_sav_mask (
    .lanes(lane_sel), .qual(state_qual), .priv(priv),
    .mode_ok(data_mode_ok), .mask(sav_mask));

  always_comb begin
    cur_next = (cur_q & ~cur_mask) | (wr_data & cur_mask);
    if (nmfi_cfg && !cur_q[FIQ_BIT]) cur_next[FIQ_BIT] = 1'b0;
    sav_next = (sav_q & ~sav_mask) | (wr_data & sav_mask);
  end

  assign bad_try = wr_en && !sel_saved && lane_sel[0] && priv && !data_mode_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q <= PSR_RESET;
      sav_q <= PSR_RESET;
      err_q <= 1'b0;
    end else begin
      err_q <= bad_try;
      if (wr_en) begin
        if (sel_saved) sav_q <= sav_next;
        else           cur_q <= cur_next;
      end
    end
  end

  assign cur_psr   = cur_q;
  assign saved_psr = sav_q;
  assign mode_err  = err_q;

  // R2: without a strobe nothing moves
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(cur_psr) && $stable(saved_psr)));
  // R12: a saved write leaves the current register alone
  a_r12_saved_isolated: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel_saved) |=> $stable(cur_psr));
  // R7: the held mode is always a legal encoding
  a_r7_mode_legal: assert property (@(posedge clk) disable iff (rst)
    held_mode_ok);
  // R6: user-mode writes never alter bits 7:6 or the mode
  a_r6_user_locked: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !sel_saved && cur_psr[4:0] == MODE_USER) |=>
      (cur_psr[7:0] & 8'hDF) == ($past(cur_psr[7:0]) & 8'hDF));
  // R10: clamp keeps a clear F bit clear
  a_r10_nmfi_clamp: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !sel_saved && nmfi_cfg && !cur_psr[FIQ_BIT]) |=> !cur_psr[FIQ_BIT]);
  // R8: the flag only follows a current-register write
  a_r8_err_cause: assert property (@(posedge clk) disable iff (rst)
    mode_err |-> $past(wr_en && !sel_saved && lane_sel[0]));
endmodule

// File: tb/psr_write_unit_bench.sv
module psr_write_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en, sel_saved, state_qual, nmfi_cfg;
  logic [3:0]  lane_sel;
  logic [31:0] wr_data;
  logic [31:0] cur_psr, saved_psr;
  logic        mode_err;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  psr_write_unit u_psr_write_unit (
    .clk(clk), .rst(rst), .wr_en(wr_en), .sel_saved(sel_saved),
    .lane_sel(lane_sel), .state_qual(state_qual), .nmfi_cfg(nmfi_cfg),
    .wr_data(wr_data), .cur_psr(cur_psr), .saved_psr(saved_psr),
    .mode_err(mode_err));

  typedef struct packed {
    logic        we;
    logic        sav;
    logic [3:0]  lanes;
    logic        qual;
    logic        nmfi;
    logic [31:0] data;
    logic [31:0] exp_cur;
    logic [31:0] exp_sav;
    logic        exp_err;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    // 0: R2 R3 R5 R7 R9, privileged full write with qualifier
    '{1'b1, 1'b0, 4'hF, 1'b1, 1'b0, 32'hFFFFFFFF, 32'hFF0FFFFF, 32'h000000D3, 1'b0},
    // 1: R3 R4 R5 R6 R8, illegal mode 00000, other lanes still written
    '{1'b1, 1'b0, 4'hF, 1'b0, 1'b0, 32'h00000000, 32'h0700FC3F, 32'h000000D3, 1'b1},
    // 2: R10 R7, F clear with clamp, data sets F, enter user mode
    '{1'b1, 1'b0, 4'h1, 1'b0, 1'b1, 32'h000000D0, 32'h0700FCB0, 32'h000000D3, 1'b0},
    // 3: R12 R5 R9 R6, user mode: bit 8 and bits 7:6 locked, bit 5 open
    '{1'b1, 1'b0, 4'hF, 1'b1, 1'b0, 32'hFFFFFFFF, 32'hFF0FFEB0, 32'h000000D3, 1'b0},
    // 4: R7 R8, user cannot change mode and raises no flag
    '{1'b1, 1'b0, 4'h1, 1'b0, 1'b0, 32'h00000013, 32'hFF0FFEB0, 32'h000000D3, 1'b0},
    // 5: R11 R4 R12, saved lanes 2 and 0, illegal mode bits ignored
    '{1'b1, 1'b1, 4'h5, 1'b0, 1'b1, 32'hAAAAAAAA, 32'hFF0FFEB0, 32'h000A00AA, 1'b0},
    // 6: R11, saved lanes 3 and 1
    '{1'b1, 1'b1, 4'hA, 1'b0, 1'b0, 32'h12345678, 32'hFF0FFEB0, 32'h120A56AA, 1'b0},
    // 7: R2, no strobe
    '{1'b0, 1'b0, 4'hF, 1'b1, 1'b0, 32'h00000000, 32'hFF0FFEB0, 32'h120A56AA, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic we, input logic sav, input logic [3:0] lanes,
                       input logic qual, input logic nmfi, input logic [31:0] data);
    wr_en = we; sel_saved = sav; lane_sel = lanes;
    state_qual = qual; nmfi_cfg = nmfi; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; sel_saved = 1'b0; lane_sel = '0;
    state_qual = 1'b0; nmfi_cfg = 1'b0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1 cur reset", cur_psr, 32'h000000D3);
    check("R1 saved reset", saved_psr, 32'h000000D3);
    check("R1 flag reset", {31'b0, mode_err}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].we, VECS[i].sav, VECS[i].lanes, VECS[i].qual,
            VECS[i].nmfi, VECS[i].data);
      check($sformatf("vec%0d R2 cur", i), cur_psr, VECS[i].exp_cur);
      check($sformatf("vec%0d R11 saved", i), saved_psr, VECS[i].exp_sav);
      check($sformatf("vec%0d R8 flag", i), {31'b0, mode_err}, {31'b0, VECS[i].exp_err});
    end

    // R1: reset again mid-run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 cur re-reset", cur_psr, 32'h000000D3);

    // R10: F set before write, clamp on, F may be cleared
    apply(1'b1, 1'b0, 4'h1, 1'b0, 1'b1, 32'h00000013);
    check("R10 clear allowed", cur_psr, 32'h00000013);
    // R10: F now clear, write sets bits 7:6, clamp keeps bit 6 low
    apply(1'b1, 1'b0, 4'h1, 1'b0, 1'b1, 32'h000000D3);
    check("R10 clamp", cur_psr, 32'h00000093);
    // R8 R9: illegal mode 10101 with qualifier, bits 7:5 still written
    apply(1'b1, 1'b0, 4'h1, 1'b1, 1'b0, 32'h00000035);
    check("R8 R9 partial write", cur_psr, 32'h00000033);
    check("R8 flag raised", {31'b0, mode_err}, 32'h1);
    apply(1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 32'h0);
    check("R8 flag one cycle", {31'b0, mode_err}, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule